// File: doc/BRIEF.md
# First-Order DC-Pass Jitter Filter

This block is a streaming first-order IIR section that sits after a loop filter. It keeps the DC part of a signed sample stream at exactly unity gain and suppresses higher-frequency content. The response falls to a null at half the sample rate. The response is one minus a first-order DC notch whose peak gain is normalized to one. That leaves a zero at z = -1 and a single pole at the programmable radius r: H(z) = (1-r)/2 · (1+z⁻¹)/(1-r·z⁻¹).

The section uses a transposed direct form II. It has one state register, two coefficient products and two sums. The feed-forward coefficient b = (1-r)/2 is derived inside the block from the pole radius, so the user supplies only r. The state carries extra fractional guard bits. This keeps rounding drift from accumulating through the pole, so a constant input settles to within one LSB of itself. Each accepted sample produces one registered output sample on the next cycle.

Top module: `dcpf_filter`

## Requirements
- R1: A synchronous reset clears the state, drives out_data to 0 and drives out_valid to 0.
- R2: out_valid equals the in_valid of the previous clock cycle.
- R3: pole_r holds an unsigned fraction r = pole_r / 2^COEF_W, which is always below one. The feed-forward weight is b = (2^COEF_W - pole_r) / 2^(COEF_W+1).
- R4: On each valid sample the block forms bx = rnd(x·2^G·(2^16-pole_r), 17) and yf = bx + s, where G = 8 guard bits. It outputs sat16(rnd(yf, 8)) and updates s to sat25(bx + rnd(yf·pole_r, 16)). Here rnd(v,k) = floor((v + 2^(k-1)) / 2^k), satN clamps to the signed N-bit range, and the default widths apply.
- R5: While in_valid is low, neither the state nor out_data changes, and the sample stream resumes unaffected.
- R6: A constant input held for several hundred samples with r = 0.9 gives an output within one LSB of that constant.
- R7: An input alternating between +A and -A every sample (half the sample rate) gives an output that decays to within one LSB of zero.
- R8: With pole_r = 0, the output is floor((x[n] + x[n-1] + 1) / 2), a two-tap average.
- R9: Results beyond the signed output range clamp to the nearest rail instead of wrapping; a full-scale positive constant yields +32767.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | DATA_W | Signed input sample |
| pole_r | input | COEF_W | Unsigned pole radius, fraction of 2^COEF_W |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | DATA_W | Signed filtered sample |

## Verification
The hardest condition to reach is the saturation path. The impulse response is positive and sums to one, so an in-range signal almost never pushes the state or the rounded output past a rail. The stimulus therefore holds full-scale constants and alternates between the two extremes under pole radii close to one, where rounding has the most room to nudge a result over the limit. A bit-exact reference model checks every such sample. Separate checks cover the settled DC level, the decay of a half-rate tone and the two-tap average at zero radius. These checks test the filter's function without relying on that model.

// File: rtl/dcpf_pkg.sv
package dcpf_pkg;
   // Default geometry shared by the filter and its bench.
   localparam int DCPF_DATA_W  = 16;
   localparam int DCPF_COEF_W  = 16;
   localparam int DCPF_GUARD_W = 8;
endpackage

// File: rtl/dcpf_mul_round.sv
// Signed operand times unsigned coefficient, scaled down by 2^SHIFT.
module dcpf_mul_round #(
   parameter int AW     = 24,
   parameter int CW     = 17,
   parameter int SHIFT  = 17,
   parameter bit RND_EN = 1'b1,
   localparam int PW    = AW + CW + 1,
   localparam int QW    = PW - SHIFT
) (
   input  logic signed [AW-1:0] a_i,
   input  logic        [CW-1:0] c_i,
   output logic signed [QW-1:0] q_o
);
   if (SHIFT < 1 || SHIFT >= PW) begin : g_bad_shift
      $error("dcpf_mul_round: SHIFT out of range");
   end

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] biased;
   logic signed [PW-1:0] scaled;

   always_comb prod = PW'(a_i) * PW'($signed({1'b0, c_i}));

   if (RND_EN) begin : g_nearest
      localparam logic signed [PW-1:0] HALF = PW'(1) <<< (SHIFT - 1);
      always_comb biased = prod + HALF;
   end else begin : g_floor
      always_comb biased = prod;
   end

   always_comb scaled = biased >>> SHIFT;
   assign q_o = scaled[QW-1:0];
endmodule

// File: rtl/dcpf_saturate.sv
// Narrows a signed value, clamping to the rails or wrapping per SAT_EN.
module dcpf_saturate #(
   parameter int IW     = 28,
   parameter int OW     = 25,
   parameter bit SAT_EN = 1'b1
) (
   input  logic signed [IW-1:0] d_i,
   output logic signed [OW-1:0] q_o
);
   if (IW < OW || OW < 2) begin : g_bad_width
      $error("dcpf_saturate: IW must be at least OW, OW at least 2");
   end

   if (IW == OW) begin : g_pass
      assign q_o = d_i;
   end else if (!SAT_EN) begin : g_wrap
      assign q_o = d_i[OW-1:0];
   end else begin : g_clamp
      localparam logic signed [OW-1:0] MAXV = {1'b0, {(OW-1){1'b1}}};
      localparam logic signed [OW-1:0] MINV = {1'b1, {(OW-1){1'b0}}};
      logic [IW-OW:0] top;
      logic           over;
      always_comb begin
         top  = d_i[IW-1:OW-1];
         over = !((&top) || (~|top));
         if (over) q_o = d_i[IW-1] ? MINV : MAXV;
         else      q_o = d_i[OW-1:0];
      end
   end
endmodule

// File: rtl/dcpf_filter.sv
module dcpf_filter
   import dcpf_pkg::*;
#(
   parameter int DATA_W  = DCPF_DATA_W,
   parameter int COEF_W  = DCPF_COEF_W,
   parameter int GUARD_W = DCPF_GUARD_W,
   parameter bit SAT_EN  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_data,
   input  logic        [COEF_W-1:0] pole_r,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_data
);
   localparam int XF_W = DATA_W + GUARD_W;   // input at fine scale
   localparam int ST_W = XF_W + 1;           // state width
   localparam int YF_W = ST_W + 1;           // fine output sum
   localparam int BC_W = COEF_W + 1;         // 2b, up to exactly one
   localparam int RY_W = YF_W + 1;           // r times fine output
   localparam int SS_W = RY_W + 1;           // unclamped next state
   localparam int YR_W = YF_W + 2 - GUARD_W; // fine output rounded down
   localparam logic [BC_W-1:0] ONE = BC_W'(1) << COEF_W;

   if (DATA_W < 2 || COEF_W < 2 || GUARD_W < 1) begin : g_bad_cfg
      $error("dcpf_filter: widths too small");
   end

   logic signed [XF_W-1:0]   x_fine;
   logic        [BC_W-1:0]   two_b;
   logic signed [ST_W-1:0]   bx;
   logic signed [YF_W-1:0]   yf;
   logic signed [RY_W-1:0]   ry;
   logic signed [SS_W-1:0]   s_sum;
   logic signed [ST_W-1:0]   s_next;
   logic signed [YR_W-1:0]   y_rnd;
   logic signed [DATA_W-1:0] y_next;
   logic signed [ST_W-1:0]   state_q;

   always_comb begin
      x_fine = {in_data, {GUARD_W{1'b0}}};
      two_b  = ONE - BC_W'(pole_r);
   end

   // b * x at fine scale: (2b * x) / 2^(COEF_W+1)
   dcpf_mul_round #(.AW(XF_W), .CW(BC_W), .SHIFT(COEF_W + 1), .RND_EN(1'b1)) u_bx (
      .a_i(x_fine), .c_i(two_b), .q_o(bx)
   );

   always_comb yf = YF_W'(bx) + YF_W'(state_q);

   // r * y feeding the state
   dcpf_mul_round #(.AW(YF_W), .CW(COEF_W), .SHIFT(COEF_W), .RND_EN(1'b1)) u_ry (
      .a_i(yf), .c_i(pole_r), .q_o(ry)
   );

   always_comb s_sum = SS_W'(ry) + SS_W'(bx);

   dcpf_saturate #(.IW(SS_W), .OW(ST_W), .SAT_EN(SAT_EN)) u_ssat (
      .d_i(s_sum), .q_o(s_next)
   );

   // Drop guard bits with rounding, then clamp to the port width
   dcpf_mul_round #(.AW(YF_W), .CW(1), .SHIFT(GUARD_W), .RND_EN(1'b1)) u_yr (
      .a_i(yf), .c_i(1'b1), .q_o(y_rnd)
   );

   dcpf_saturate #(.IW(YR_W), .OW(DATA_W), .SAT_EN(SAT_EN)) u_osat (
      .d_i(y_rnd), .q_o(y_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= '0;
         out_data  <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            state_q  <= s_next;
            out_data <= y_next;
         end
      end
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && out_data == '0 && state_q == '0));
   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   // R2
   valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   // R5
   data_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_data));
   // R5
   state_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(state_q));
endmodule

// File: tb/dcpf_filter_bench.sv
module dcpf_filter_bench;
   localparam real HALF_NS = 2.5;   // 200 MHz

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               in_valid = 1'b0;
   logic signed [15:0] in_data = '0;
   logic        [15:0] pole_r = '0;
   logic               out_valid;
   logic signed [15:0] out_data;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   longint ms = 0;            // model state
   longint last_y = 0;

   always #(HALF_NS) clk = ~clk;

   dcpf_filter u_dcpf_filter (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .pole_r(pole_r), .out_valid(out_valid), .out_data(out_data)
   );

   function automatic longint rnd(longint v, int k);
      return (v + (longint'(1) <<< (k - 1))) >>> k;
   endfunction

   function automatic longint sat(longint v, int w);
      longint hi = (longint'(1) <<< (w - 1)) - 1;
      longint lo = -(longint'(1) <<< (w - 1));
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   // R4 reference arithmetic
   function automatic longint model_step(longint x, longint r);
      longint bx = rnd((x <<< 8) * (65536 - r), 17);
      longint yf = bx + ms;
      longint ry = rnd(yf * r, 16);
      ms = sat(bx + ry, 25);
      return sat(rnd(yf, 8), 16);
   endfunction

   task automatic chk(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b1; in_data = 16'sd1234;
      @(posedge clk); @(posedge clk); #1;
      chk(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);
      chk(out_data == 16'sd0, "R1 data", longint'(out_data), 0);
      @(negedge clk);
      rst = 1'b0; in_valid = 1'b0;
      ms = 0; last_y = 0;
   endtask

   // Drive one cycle; return the registered output after the edge.
   task automatic push(longint x, bit v, bit do_chk, output longint y);
      longint exp;
      @(negedge clk);
      in_data = 16'(x); in_valid = v;
      @(posedge clk); #1;
      y = longint'(out_data);
      if (v) begin
         exp = model_step(x, longint'(pole_r));
         if (do_chk) begin
            chk(out_valid == 1'b1, "R2 valid high", longint'(out_valid), 1);
            chk(y == exp, "R4 sample", y, exp);
         end
         last_y = exp;
      end else if (do_chk) begin
         chk(out_valid == 1'b0, "R2 valid low", longint'(out_valid), 0);
         chk(y == last_y, "R5 hold", y, last_y);
      end
   endtask

   initial begin
      #(HALF_NS * 2.0 * 150000.0);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      longint y, xp, av;
      void'($urandom(32'd20080603));
      do_reset();

      // R8: zero radius gives a two-tap average
      pole_r = 16'd0; xp = 0;
      for (int i = 0; i < 40; i++) begin
         longint x = (i == 3) ? 32767 : (i == 4) ? -32768 : longint'($signed(16'($urandom)));
         push(x, 1'b1, 1'b1, y);
         av = (x + xp + 1) >>> 1;
         chk(y == av, "R8 average", y, av);
         xp = x;
      end

      // R6: DC settles within one LSB at r = 0.9
      do_reset();
      pole_r = 16'd58982;
      for (int i = 0; i < 400; i++) push(12345, 1'b1, 1'b1, y);
      chk(y >= 12344 && y <= 12346, "R6 dc positive", y, 12345);
      for (int i = 0; i < 400; i++) push(-20000, 1'b1, 1'b1, y);
      chk(y >= -20001 && y <= -19999, "R6 dc negative", y, -20000);

      // R7: half-rate tone is nulled
      do_reset();
      pole_r = 16'd58982;
      for (int i = 0; i < 400; i++) push((i % 2) ? -10000 : 10000, 1'b1, 1'b1, y);
      chk(y >= -1 && y <= 1, "R7 nyquist null", y, 0);

      // R9: full-scale inputs clamp to the rails
      do_reset();
      pole_r = 16'd65535;
      for (int i = 0; i < 50; i++) push(32767, 1'b1, 1'b1, y);
      pole_r = 16'd62000;
      for (int i = 0; i < 400; i++) push(32767, 1'b1, 1'b1, y);
      chk(y == 32767, "R9 positive rail", y, 32767);
      for (int i = 0; i < 400; i++) push(-32768, 1'b1, 1'b1, y);
      chk(y == -32768, "R9 negative rail", y, -32768);
      for (int i = 0; i < 200; i++) push((i % 2) ? -32768 : 32767, 1'b1, 1'b1, y);
      chk(y >= -1 && y <= 1, "R9 R7 extremes null", y, 0);

      // R3 R5 R2: random radii, random gaps, random data
      for (int blk = 0; blk < 20; blk++) begin
         pole_r = (blk == 0) ? 16'd0 : (blk == 1) ? 16'd65535 : 16'($urandom);
         for (int i = 0; i < 300; i++) begin
            bit v = ($urandom % 10) < 7;
            longint x = ($urandom % 8 == 0) ? (($urandom % 2) ? 32767 : -32768)
                                            : longint'($signed(16'($urandom)));
            push(x, v, 1'b1, y);
         end
      end

      // R1: reset mid-stream, then filter restarts from zero state
      do_reset();
      pole_r = 16'd0;
      push(100, 1'b1, 1'b1, y);
      chk(y == 50, "R1 R8 restart", y, 50);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule